// File: doc/BRIEF.md
# Graded Arc Recovery Sequencer

This block sits between an arc detector and the command inputs of a high-voltage supply that holds a wafer electrostatically. When an arc is reported, it does not shut the supply off. It lowers the voltage command to a reduced level and raises the oscillator frequency command above its nominal value in the same step. It then waits for a programmable settling time. Finally it brings both commands back to nominal along a smooth S-shaped curve, so that the arc does not re-ignite. A 1 µs timebase strobe paces every phase.

The sequence has four phases: `PH_IDLE` (0), `PH_FOLD` (1), `PH_HOLD` (2) and `PH_RAMP` (3). The phase is reported on `phase`. The transitions are named as follows:
- *arc_start*: IDLE→FOLD on an arc.
- *fold_done*: FOLD→HOLD after 32 ticks.
- *hold_done*: HOLD→RAMP after `hold_len` ticks.
- *ramp_done*: RAMP→IDLE after 10,000 ticks.
- *restrike*: HOLD→FOLD or RAMP→FOLD on an arc.

Each restrike is counted within the current sequence. A sticky fault flag reports a sequence that keeps re-arcing.

Top module: `arc_recovery_seq`

## Requirements
- R1: After reset, `phase` is 0 (IDLE), `fault` is 0, `volt_cmd` equals `nom_volt` and `freq_cmd` equals `nom_freq`.
- R2: An arc in IDLE gives `phase` = 1 (FOLD) after the next clock edge. From that edge until RAMP, `freq_cmd` = `nom_freq` + floor(`nom_freq`·(32+min(`boost_code`,32))/64), which is a boost of 50 % to 100 %.
- R3: The fold target is floor(`nom_volt`·80/100). After k ticks in FOLD, `volt_cmd` = start − floor((start − target)·k/32). The target is reached after 32 ticks, when `phase` becomes 2 (HOLD).
- R4: HOLD keeps `volt_cmd` at the target and `freq_cmd` at the boosted value. It lasts exactly `hold_len` ticks, and then `phase` becomes 3 (RAMP).
- R5: After j ticks in RAMP, `volt_cmd` = target + (`nom_volt` − target)·S(j/10000), within ±4 LSB, where S(t) = 3t² − 2t³. After 10,000 ticks, `phase` is 0 and `volt_cmd` equals `nom_volt`.
- R6: During RAMP, `freq_cmd` = boosted − (boosted − `nom_freq`)·S(j/10000), within ±4 LSB. It equals `nom_freq` again in IDLE.
- R7: Outside IDLE, `volt_cmd` never drops below the fold target. The output is never commanded to zero.
- R8: An arc in HOLD or RAMP restarts FOLD at the next edge. The restart begins from the `volt_cmd` value present at that edge, and the restrike count rises by one.
- R9: An arc during FOLD is ignored. FOLD still ends 32 ticks after it began.
- R10: The fourth restrike within one sequence sets `fault`. The count clears when a new sequence starts from IDLE.
- R11: `fault` stays set until `fault_clr` is high at a clock edge. A restrike that sets `fault` on the same edge wins over the clear.
- R12: The phase timers advance only on clock edges where `tick_us` is high. With `tick_us` low, the phase does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 µs timebase strobe |
| arc_hit | input | 1 | One-cycle arc detect pulse |
| nom_volt | input | 16 | Nominal voltage setpoint |
| nom_freq | input | 16 | Nominal oscillator frequency command |
| boost_code | input | 6 | Frequency boost in 64ths above one half (saturates at 32) |
| hold_len | input | 16 | HOLD duration in ticks |
| fault_clr | input | 1 | Clears the sticky fault flag |
| volt_cmd | output | 16 | Voltage setpoint command |
| freq_cmd | output | 17 | Oscillator frequency command |
| phase | output | 2 | Current phase: 0 IDLE, 1 FOLD, 2 HOLD, 3 RAMP |
| fault | output | 1 | Sticky repeated-restrike fault |

## Verification
The assertions assume the following about the inputs:
- `nom_volt`, `nom_freq`, `boost_code` and `hold_len` stay constant from the start of a sequence until it returns to IDLE.
- `arc_hit` is a single-cycle pulse.

If either assumption is broken, the floor checks against the fold target and the range checks on the interpolators would no longer apply. The stimulus changes the nominal values only while the block is idle, and every arc it drives lasts exactly one clock. Each tested case holds its settings across the whole fold, hold and ramp.

// File: rtl/arc_seq_pkg.sv
package arc_seq_pkg;
    // Fraction width of the unit interval used by the interpolators (1.0 = 2**FRAC_W)
    localparam int FRAC_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FOLD = 2'd1,
        PH_HOLD = 2'd2,
        PH_RAMP = 2'd3
    } phase_e;
endpackage

// File: rtl/arc_smoothstep.sv
module arc_smoothstep
    import arc_seq_pkg::*;
#(
    parameter int TICKS = 10000,
    parameter int POS_W = 14
) (
    input  logic [POS_W-1:0]  pos,
    output logic [FRAC_W:0]   shape
);
    // Reciprocal of the ramp length, so that no divider is needed
    localparam logic [63:0]     RECIP = ((64'd1 << (2*FRAC_W)) + 64'(TICKS) - 64'd1) / 64'(TICKS);
    localparam logic [FRAC_W:0] ONE   = {1'b1, {FRAC_W{1'b0}}};

    logic [63:0]          scaled;
    logic [FRAC_W:0]      t_lin;
    logic [2*FRAC_W+1:0]  sq_full;
    logic [FRAC_W:0]      t_sq;
    logic [2*FRAC_W+1:0]  cu_full;
    logic [FRAC_W:0]      t_cu;
    logic [FRAC_W+2:0]    poly;

    always_comb begin
        scaled  = (64'(pos) * RECIP) >> FRAC_W;
        t_lin   = (scaled > 64'(ONE)) ? ONE : (FRAC_W+1)'(scaled);
        sq_full = {{(FRAC_W+1){1'b0}}, t_lin} * {{(FRAC_W+1){1'b0}}, t_lin};
        t_sq    = (FRAC_W+1)'(sq_full >> FRAC_W);
        cu_full = {{(FRAC_W+1){1'b0}}, t_sq} * {{(FRAC_W+1){1'b0}}, t_lin};
        t_cu    = (FRAC_W+1)'(cu_full >> FRAC_W);
        // 3t^2 - 2t^3 = t^2 + 2t^2 - 2t^3
        poly    = {2'b00, t_sq} + {1'b0, t_sq, 1'b0} - {1'b0, t_cu, 1'b0};
        shape   = (poly > {2'b00, ONE}) ? ONE : (FRAC_W+1)'(poly);
    end

    // R5
    always_comb begin
        shape_unit_chk: assert (shape <= ONE && (pos != '0 || shape == '0))
            else $error("smoothstep out of unit range");
    end
endmodule

// File: rtl/arc_blend.sv
module arc_blend
    import arc_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    from_v,
    input  logic [W-1:0]    to_v,
    input  logic [FRAC_W:0] weight,
    output logic [W-1:0]    mix
);
    logic             rising;
    logic [W-1:0]     span;
    logic [W+FRAC_W:0] prod;
    logic [W-1:0]     delta;

    always_comb begin
        rising = (to_v >= from_v);
        span   = rising ? (to_v - from_v) : (from_v - to_v);
        prod   = {{(FRAC_W+1){1'b0}}, span} * {{W{1'b0}}, weight};
        delta  = W'(prod >> FRAC_W);
        mix    = rising ? (from_v + delta) : (from_v - delta);
    end

    // R7
    always_comb begin
        blend_range_chk: assert ((rising && mix >= from_v && mix <= to_v) ||
                                 (!rising && mix <= from_v && mix >= to_v))
            else $error("blend left its endpoints");
    end
endmodule

// File: rtl/arc_freq_boost.sv
module arc_freq_boost #(
    parameter int FQ_W        = 16,
    parameter int BOOST_SHIFT = 6
) (
    input  logic [FQ_W-1:0]        base,
    input  logic [BOOST_SHIFT-1:0] code,
    output logic [FQ_W:0]          boosted
);
    localparam logic [BOOST_SHIFT:0] HALF = (BOOST_SHIFT+1)'(1) << (BOOST_SHIFT-1);

    logic [BOOST_SHIFT:0]        gain;
    logic [FQ_W+BOOST_SHIFT:0]   prod;

    always_comb begin
        gain    = ({1'b0, code} > HALF) ? (HALF + HALF) : (HALF + {1'b0, code});
        prod    = {{(BOOST_SHIFT+1){1'b0}}, base} * {{FQ_W{1'b0}}, gain};
        boosted = {1'b0, base} + (FQ_W+1)'(prod >> BOOST_SHIFT);
    end

    // R2
    always_comb begin
        boost_band_chk: assert (boosted >= {1'b0, base} + {2'b00, base[FQ_W-1:1]} &&
                                boosted <= {base, 1'b0})
            else $error("boost outside 50..100 percent");
    end
endmodule

// File: rtl/arc_recovery_seq.sv
module arc_recovery_seq
    import arc_seq_pkg::*;
#(
    parameter int SP_W         = 16,
    parameter int FQ_W         = 16,
    parameter int BOOST_SHIFT  = 6,
    parameter int HOLD_W       = 16,
    parameter int FOLD_SHIFT   = 5,
    parameter int FOLD_PCT     = 80,
    parameter int RAMP_TICKS   = 10000,
    parameter int STRIKE_LIMIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_us,
    input  logic                   arc_hit,
    input  logic [SP_W-1:0]        nom_volt,
    input  logic [FQ_W-1:0]        nom_freq,
    input  logic [BOOST_SHIFT-1:0] boost_code,
    input  logic [HOLD_W-1:0]      hold_len,
    input  logic                   fault_clr,
    output logic [SP_W-1:0]        volt_cmd,
    output logic [FQ_W:0]          freq_cmd,
    output logic [1:0]             phase,
    output logic                   fault
);
    localparam int FOLD_TICKS = 1 << FOLD_SHIFT;
    localparam int RAMP_CW    = $clog2(RAMP_TICKS + 1);
    localparam int CW_A       = (RAMP_CW > HOLD_W) ? RAMP_CW : HOLD_W;
    localparam int CW         = (CW_A > FOLD_SHIFT + 1) ? CW_A : FOLD_SHIFT + 1;
    localparam int STRIKE_W   = $clog2(STRIKE_LIMIT + 1);

    phase_e               st;
    logic [CW-1:0]        cnt;
    logic [SP_W-1:0]      start_v;
    logic [STRIKE_W-1:0]  strikes;

    logic [SP_W+7:0]      tgt_full;
    logic [SP_W-1:0]      fold_tgt;
    logic [FQ_W:0]        freq_hi;
    logic [FRAC_W:0]      fold_w;
    logic [FRAC_W:0]      ramp_w;
    logic [SP_W-1:0]      fold_v;
    logic [SP_W-1:0]      ramp_v;
    logic [FQ_W:0]        ramp_f;
    logic                 restrike;
    logic                 fold_done;
    logic                 hold_done;
    logic                 ramp_done;

    // Fold-back target and boosted frequency
    always_comb begin
        tgt_full = ({8'b0, nom_volt} * (SP_W+8)'(FOLD_PCT)) / (SP_W+8)'(100);
        fold_tgt = SP_W'(tgt_full);
        fold_w   = (FRAC_W+1)'(cnt[FOLD_SHIFT-1:0]) << (FRAC_W - FOLD_SHIFT);
    end

    arc_freq_boost #(.FQ_W(FQ_W), .BOOST_SHIFT(BOOST_SHIFT)) i_boost (
        .base    (nom_freq),
        .code    (boost_code),
        .boosted (freq_hi)
    );

    arc_smoothstep #(.TICKS(RAMP_TICKS), .POS_W(RAMP_CW)) i_shape (
        .pos   (cnt[RAMP_CW-1:0]),
        .shape (ramp_w)
    );

    arc_blend #(.W(SP_W)) i_fold_volt (
        .from_v (start_v),
        .to_v   (fold_tgt),
        .weight (fold_w),
        .mix    (fold_v)
    );

    arc_blend #(.W(SP_W)) i_ramp_volt (
        .from_v (fold_tgt),
        .to_v   (nom_volt),
        .weight (ramp_w),
        .mix    (ramp_v)
    );

    arc_blend #(.W(FQ_W+1)) i_ramp_freq (
        .from_v (freq_hi),
        .to_v   ({1'b0, nom_freq}),
        .weight (ramp_w),
        .mix    (ramp_f)
    );

    // Transition conditions
    always_comb begin
        restrike  = arc_hit && (st == PH_HOLD || st == PH_RAMP);
        fold_done = tick_us && (cnt == CW'(FOLD_TICKS - 1));
        hold_done = tick_us && (({1'b0, cnt} + (CW+1)'(1)) >= (CW+1)'(hold_len));
        ramp_done = tick_us && (cnt == CW'(RAMP_TICKS - 1));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            cnt     <= '0;
            start_v <= '0;
            strikes <= '0;
            fault   <= 1'b0;
        end else begin
            if (restrike && strikes >= STRIKE_W'(STRIKE_LIMIT - 1))
                fault <= 1'b1;
            else if (fault_clr)
                fault <= 1'b0;

            unique case (st)
                PH_IDLE: begin
                    if (arc_hit) begin
                        st      <= PH_FOLD;
                        cnt     <= '0;
                        start_v <= volt_cmd;
                        strikes <= '0;
                    end
                end
                PH_FOLD: begin
                    if (fold_done) begin
                        st  <= PH_HOLD;
                        cnt <= '0;
                    end else if (tick_us) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_HOLD, PH_RAMP: begin
                    if (restrike) begin
                        st      <= PH_FOLD;
                        cnt     <= '0;
                        start_v <= volt_cmd;
                        if (strikes != STRIKE_W'(STRIKE_LIMIT))
                            strikes <= strikes + STRIKE_W'(1);
                    end else if (st == PH_HOLD && hold_done) begin
                        st  <= PH_RAMP;
                        cnt <= '0;
                    end else if (st == PH_RAMP && ramp_done) begin
                        st  <= PH_IDLE;
                        cnt <= '0;
                    end else if (tick_us) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Command outputs
    always_comb begin
        phase = st;
        unique case (st)
            PH_IDLE: begin
                volt_cmd = nom_volt;
                freq_cmd = {1'b0, nom_freq};
            end
            PH_FOLD: begin
                volt_cmd = fold_v;
                freq_cmd = freq_hi;
            end
            PH_HOLD: begin
                volt_cmd = fold_tgt;
                freq_cmd = freq_hi;
            end
            PH_RAMP: begin
                volt_cmd = ramp_v;
                freq_cmd = ramp_f;
            end
            default: begin
                volt_cmd = nom_volt;
                freq_cmd = {1'b0, nom_freq};
            end
        endcase
    end

    // R2
    arc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && arc_hit) |=> (phase == PH_FOLD));

    // R3
    fold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_FOLD && tick_us && cnt == CW'(FOLD_TICKS - 1)) |=> (phase == PH_HOLD));

    // R4
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HOLD) |-> (volt_cmd == fold_tgt && freq_cmd == freq_hi));

    // R7
    no_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE) |-> (volt_cmd >= fold_tgt && (nom_volt == '0 || volt_cmd != '0)));

    // R8
    restrike_from_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restrike |=> (phase == PH_FOLD && volt_cmd == $past(volt_cmd)));

    // R9
    fold_ignores_arc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_FOLD && arc_hit && !tick_us) |=> (phase == PH_FOLD && $stable(cnt)));

    // R10
    strike_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restrike && strikes == STRIKE_W'(STRIKE_LIMIT - 1)) |=> fault);

    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    // R12
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE && !tick_us && !arc_hit) |=> ($stable(cnt) && phase == $past(phase)));
endmodule

// File: tb/test_arc_recovery_seq.sv
module test_arc_recovery_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;

    // Table: nominal volt, nominal freq, boost code, expected target, boosted freq, volt after 16 fold ticks
    localparam int V_VOLT[NVEC]  = '{50000, 10000, 65535, 1000};
    localparam int V_FREQ[NVEC]  = '{20000, 1000, 65535, 12800};
    localparam int V_CODE[NVEC]  = '{0, 32, 63, 16};
    localparam int V_TGT[NVEC]   = '{40000, 8000, 52428, 800};
    localparam int V_FHI[NVEC]   = '{30000, 2000, 131070, 22400};
    localparam int V_FMID[NVEC]  = '{45000, 9000, 58982, 900};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_us;
    logic        arc_hit;
    logic [15:0] nom_volt;
    logic [15:0] nom_freq;
    logic [5:0]  boost_code;
    logic [15:0] hold_len;
    logic        fault_clr;
    logic [15:0] volt_cmd;
    logic [16:0] freq_cmd;
    logic [1:0]  phase;
    logic        fault;

    int checks = 0;
    int fails  = 0;

    arc_recovery_seq i_arc_recovery_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .arc_hit    (arc_hit),
        .nom_volt   (nom_volt),
        .nom_freq   (nom_freq),
        .boost_code (boost_code),
        .hold_len   (hold_len),
        .fault_clr  (fault_clr),
        .volt_cmd   (volt_cmd),
        .freq_cmd   (freq_cmd),
        .phase      (phase),
        .fault      (fault)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp, input longint tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real sstep(input real t);
        return 3.0*t*t - 2.0*t*t*t;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        arc_hit = 1'b1;
        @(negedge clk);
        arc_hit = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        longint prev;
        real    e;
        rst_n = 1'b0; tick_us = 1'b1; arc_hit = 1'b0; fault_clr = 1'b0;
        nom_volt = 16'd50000; nom_freq = 16'd20000; boost_code = 6'd0; hold_len = 16'd4;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 phase", phase, 0, 0);
        chk("R1 volt", volt_cmd, 50000, 0);
        chk("R1 freq", freq_cmd, 20000, 0);
        chk("R1 fault", fault, 0, 0);

        // Table-driven full sequences
        for (int i = 0; i < NVEC; i++) begin
            nom_volt   = 16'(V_VOLT[i]);
            nom_freq   = 16'(V_FREQ[i]);
            boost_code = 6'(V_CODE[i]);
            step(1);
            fire();
            chk("R2 phase fold", phase, 1, 0);
            chk("R2 boosted freq", freq_cmd, V_FHI[i], 0);
            chk("R3 fold start", volt_cmd, V_VOLT[i], 0);
            step(16);
            chk("R3 fold midway", volt_cmd, V_FMID[i], 0);
            step(16);
            chk("R3 phase hold", phase, 2, 0);
            chk("R4 hold volt", volt_cmd, V_TGT[i], 0);
            chk("R4 hold freq", freq_cmd, V_FHI[i], 0);
            step(4);
            chk("R4 phase ramp", phase, 3, 0);
            chk("R5 ramp start", volt_cmd, V_TGT[i], 0);
            for (int q = 1; q < 4; q++) begin
                step(2500);
                e = V_TGT[i] + (V_VOLT[i] - V_TGT[i]) * sstep(q * 0.25);
                chk("R5 ramp volt", volt_cmd, longint'($rtoi(e)), 4);
                e = V_FHI[i] + (V_FREQ[i] - V_FHI[i]) * sstep(q * 0.25);
                chk("R6 ramp freq", freq_cmd, longint'($rtoi(e)), 4);
                chk("R7 above target", (volt_cmd >= 16'(V_TGT[i])) ? 1 : 0, 1, 0);
            end
            step(2500);
            chk("R5 back idle", phase, 0, 0);
            chk("R5 volt nominal", volt_cmd, V_VOLT[i], 0);
            chk("R6 freq nominal", freq_cmd, V_FREQ[i], 0);
        end

        // R9, R4 exact hold length, R12 tick gating, R8/R10/R11 restrikes
        nom_volt = 16'd50000; nom_freq = 16'd20000; boost_code = 6'd0; hold_len = 16'd200;
        step(1);
        fire();
        step(10);
        fire();
        step(21);
        chk("R9 fold not restarted", phase, 2, 0);
        step(199);
        chk("R4 hold still active", phase, 2, 0);
        tick_us = 1'b0;
        step(50);
        chk("R12 no tick no advance", phase, 2, 0);
        tick_us = 1'b1;
        step(1);
        chk("R12 advance on tick", phase, 3, 0);
        step(2500);
        prev = longint'(volt_cmd);
        fire();
        chk("R8 restrike phase", phase, 1, 0);
        chk("R8 restart from current", volt_cmd, prev, 0);
        step(32);
        chk("R8 refold target", volt_cmd, 40000, 0);
        fire();
        step(32);
        fire();
        chk("R10 three restrikes no fault", fault, 0, 0);
        step(32);
        fire();
        chk("R10 fourth restrike fault", fault, 1, 0);
        step(5);
        chk("R11 fault sticky", fault, 1, 0);
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        chk("R11 fault cleared", fault, 0, 0);
        step(10226);
        chk("R5 sequence ends idle", phase, 0, 0);
        chk("R5 idle volt", volt_cmd, 50000, 0);

        // R10 count resets per sequence, R11 set beats clear
        hold_len = 16'd4;
        fire();
        step(32);
        fire();
        step(32);
        fire();
        step(32);
        fire();
        chk("R10 count cleared per sequence", fault, 0, 0);
        step(32);
        fault_clr = 1'b1;
        fire();
        fault_clr = 1'b0;
        chk("R11 set wins over clear", fault, 1, 0);
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        chk("R11 clear after set", fault, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule